// File: doc/BRIEF.md
# Exception Entry and Vector Controller

This block performs the entry half of exception handling for a simple in-order core. It holds the exception control registers and the three-stage program-counter chain: current PC, next PC and next-next PC. The core raises one request at a time. A request carries a kind code and its side data: the faulting address, the virtual page number, the ASID and a coprocessor number.

On the clock edge that accepts a request, the block does all of the following together:
- marks the core as being at exception level;
- records the return address and the branch-delay-slot flag;
- writes the cause code;
- swaps the shadow register set when that is allowed;
- captures the translation context when the kind needs it;
- moves the PC chain to the selected handler.

A one-cycle pulse then tells the core that the new PC chain is valid.

Outside exception entry, the core moves the PC chain forward one instruction at a time with a step strobe. A step may carry a branch target, which becomes the PC after the delay slot. Software reads and writes every register through a small address-mapped port, and reads return combinationally. After reset the chain starts at the reset vector.

Top module: `exc_entry_unit`

## Requirements
- R1: After reset the PC chain holds the reset vector (default 0xBFC00000), +4 and +8. Status reads 0x20000000 (bit 29, coprocessor-1 usable), EBase reads 0x80000000, all other registers read 0 and the redirect pulse is low.
- R2: Request kinds and the cause code each writes into Cause[6:2]:

  | Kind | Exception | Cause code |
  |---|---|---|
  | 0 | interrupt | 0x0 |
  | 1 | TLB modified | 0x1 |
  | 2 | load or fetch TLB refill | 0x2 |
  | 3 | load or fetch TLB invalid | 0x2 |
  | 4 | store TLB refill | 0x3 |
  | 5 | store TLB invalid | 0x3 |
  | 6 | load address error | 0x4 |
  | 7 | store address error | 0x5 |
  | 8 | system call | 0x8 |
  | 9 | breakpoint | 0x9 |
  | 10 | reserved instruction | 0xA |
  | 11 | coprocessor unusable | 0xB |
  | 12 | overflow | 0xC |
  | 13 | trap | 0xD |

  Kinds 14 and 15 are not accepted and change nothing.
- R3: Every accepted entry sets Status[1] (EXL), even when it is already set.
- R4: The shadow-control fields are current set [3:0], previous set [9:6] and exception set [15:12]. On entry, and only when Status[1] (EXL) and Status[22] (BEV) were both 0, the previous set takes the old current set and the current set takes the exception set. Otherwise these fields are unchanged.
- R5: A step moves the PC chain forward by one instruction. A step with a branch makes next PC the branch target and next-next PC the target + 4. On entry, if PC + 4 differs from next PC, EPC gets PC − 4 and Cause[31] (BD) is set. Otherwise EPC gets PC and BD is cleared.
- R6: Every entry clears Cause[29:28] (CE). A coprocessor-unusable entry then loads CE with the requested coprocessor number.
- R7: The general handler is EBase + 0x180. It serves every kind not named in R8–R10.
- R8: A TLB refill (kinds 2 and 4) goes to EBase + 0x000 when EXL was 0 before the entry, and to EBase + 0x180 when EXL was already 1.
- R9: An interrupt goes to EBase + 0x200 when Cause[23] (IV) is 1, and to EBase + 0x180 when IV is 0.
- R10: Overflow goes to 0xBFC00200 when Status[22] (BEV) is 1, and to EBase + 0x180 when BEV is 0.
- R11: On the entry edge the PC chain becomes handler, handler + 4 and handler + 8. All register updates commit on that same edge. The redirect pulse is high for exactly the following cycle.
- R12: Address-error and TLB entries write the request address to BadVAddr. TLB entries also write EntryHi[31:13] with the VPN, EntryHi[7:0] with the ASID, and Context[22:4] with the VPN. No other entry kind changes these registers.
- R13: A software write in the same cycle as an entry is dropped for the fields that the entry updates, and applies to all other fields. The handler address is always computed from the register values held before that edge.
- R14: The register port maps address 0 to Status, 1 to Cause, 2 to EPC, 3 to BadVAddr, 4 to EntryHi, 5 to Context, 6 to shadow control and 7 to EBase. A write lands on the clock edge, and a read returns the stored value combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| excValid | input | 1 | Exception request this cycle |
| excKind | input | 4 | Request kind code |
| badAddr | input | 32 | Faulting virtual address |
| reqVpn2 | input | 19 | Faulting virtual page pair number |
| reqAsid | input | 8 | Address space identifier of the access |
| copNum | input | 2 | Coprocessor number for an unusable fault |
| regWrEn | input | 1 | Software register write strobe |
| regAddr | input | 3 | Software register address |
| regWrData | input | 32 | Software write data |
| regRdData | output | 32 | Software read data |
| stepEn | input | 1 | Advance the PC chain by one instruction |
| branchEn | input | 1 | The step carries a taken branch |
| branchTarget | input | 32 | Target of that branch |
| pc | output | 32 | Current PC |
| nextPc | output | 32 | Next PC |
| nextNextPc | output | 32 | Next-next PC |
| redirectValid | output | 1 | One-cycle pulse after an entry redirect |

## Verification
The hardest states to reach are those where an entry depends on history rather than on the request itself. The delay-slot case needs the chain to hold a PC whose successor is not PC + 4. The stimulus gets there with a branch-carrying step just before the request. The refill and overflow vectors, and the gating of the shadow swap, depend on the EXL and BEV values from the previous entry. The bench therefore chains entries back to back and sets those bits through the port only when a scenario needs them. The collision rule is reached by pulsing the port write in the very cycle the request is raised, once each for EPC, Status and EBase.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  // Request kind codes seen on excKind
  typedef enum logic [3:0] {
    KIND_INT        = 4'd0,
    KIND_TLB_MOD    = 4'd1,
    KIND_LD_REFILL  = 4'd2,
    KIND_LD_INVALID = 4'd3,
    KIND_ST_REFILL  = 4'd4,
    KIND_ST_INVALID = 4'd5,
    KIND_ADDR_LD    = 4'd6,
    KIND_ADDR_ST    = 4'd7,
    KIND_SYSCALL    = 4'd8,
    KIND_BREAK      = 4'd9,
    KIND_RESV       = 4'd10,
    KIND_COP        = 4'd11,
    KIND_OVF        = 4'd12,
    KIND_TRAP       = 4'd13
  } exc_kind_e;

  // Handler address selection
  typedef enum logic [1:0] {
    VEC_BASE    = 2'd0,
    VEC_GENERAL = 2'd1,
    VEC_IRQ     = 2'd2,
    VEC_FIXED   = 2'd3
  } vec_sel_e;

  localparam int CODE_W = 5;

  // Strobes from the decode control to the register datapath
  typedef struct packed {
    logic              enter;
    logic [CODE_W-1:0] code;
    logic              wrBadAddr;
    logic              wrTlbCtx;
    logic              loadCe;
    vec_sel_e          vecSel;
  } entry_strobe_t;

  // Field positions decoded by software and neighbouring logic
  localparam int STATUS_EXL    = 1;
  localparam int STATUS_BEV    = 22;
  localparam int STATUS_CU1    = 29;
  localparam int CAUSE_CODE_LO = 2;
  localparam int CAUSE_IV      = 23;
  localparam int CAUSE_CE_LO   = 28;
  localparam int CAUSE_BD      = 31;
  localparam int CE_W          = 2;
  localparam int SET_W         = 4;
  localparam int SHD_CUR_LO    = 0;
  localparam int SHD_PREV_LO   = 6;
  localparam int SHD_EXC_LO    = 12;
  localparam int VPN_W         = 19;
  localparam int ASID_W        = 8;
  localparam int EHI_VPN_LO    = 13;
  localparam int CTX_VPN_LO    = 4;

  // Register port map
  localparam int REG_ADDR_W = 3;
  localparam int NUM_REGS   = 1 << REG_ADDR_W;
  localparam int REG_STATUS = 0;
  localparam int REG_CAUSE  = 1;
  localparam int REG_EPC    = 2;
  localparam int REG_BADVA  = 3;
  localparam int REG_EHI    = 4;
  localparam int REG_CTX    = 5;
  localparam int REG_SHADOW = 6;
  localparam int REG_EBASE  = 7;

endpackage

// File: rtl/exc_entry_decode.sv
module exc_entry_decode
  import exc_entry_pkg::*;
(
  input  logic          excValid,
  input  logic [3:0]    excKind,
  input  logic          exlNow,
  input  logic          bevNow,
  input  logic          ivNow,
  output entry_strobe_t strobe
);

  logic known;

  always_comb begin
    strobe = '0;
    strobe.vecSel = VEC_GENERAL;
    known = 1'b1;
    case (excKind)
      KIND_INT: begin
        strobe.code   = 5'h00;
        strobe.vecSel = ivNow ? VEC_IRQ : VEC_GENERAL;
      end
      KIND_TLB_MOD: begin
        strobe.code      = 5'h01;
        strobe.wrBadAddr = 1'b1;
        strobe.wrTlbCtx  = 1'b1;
      end
      KIND_LD_REFILL, KIND_ST_REFILL: begin
        strobe.code      = (excKind == KIND_LD_REFILL) ? 5'h02 : 5'h03;
        strobe.wrBadAddr = 1'b1;
        strobe.wrTlbCtx  = 1'b1;
        // refill vector uses EXL as it was before this entry
        strobe.vecSel    = exlNow ? VEC_GENERAL : VEC_BASE;
      end
      KIND_LD_INVALID, KIND_ST_INVALID: begin
        strobe.code      = (excKind == KIND_LD_INVALID) ? 5'h02 : 5'h03;
        strobe.wrBadAddr = 1'b1;
        strobe.wrTlbCtx  = 1'b1;
      end
      KIND_ADDR_LD, KIND_ADDR_ST: begin
        strobe.code      = (excKind == KIND_ADDR_LD) ? 5'h04 : 5'h05;
        strobe.wrBadAddr = 1'b1;
      end
      KIND_SYSCALL: strobe.code = 5'h08;
      KIND_BREAK:   strobe.code = 5'h09;
      KIND_RESV:    strobe.code = 5'h0A;
      KIND_COP: begin
        strobe.code   = 5'h0B;
        strobe.loadCe = 1'b1;
      end
      KIND_OVF: begin
        strobe.code   = 5'h0C;
        strobe.vecSel = bevNow ? VEC_FIXED : VEC_GENERAL;
      end
      KIND_TRAP:    strobe.code = 5'h0D;
      default:      known = 1'b0;
    endcase
    strobe.enter = excValid && known;
  end

endmodule

// File: rtl/exc_entry_regs.sv
module exc_entry_regs
  import exc_entry_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_VEC  = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] EBASE_RST  = 32'h8000_0000,
  parameter logic [XLEN-1:0] FIXED_VEC  = 32'hBFC0_0200,
  parameter int              INSN_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  entry_strobe_t         strobe,
  input  logic [XLEN-1:0]       badAddr,
  input  logic [VPN_W-1:0]      reqVpn2,
  input  logic [ASID_W-1:0]     reqAsid,
  input  logic [CE_W-1:0]       copNum,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [XLEN-1:0]       regWrData,
  output logic [XLEN-1:0]       regRdData,
  input  logic                  stepEn,
  input  logic                  branchEn,
  input  logic [XLEN-1:0]       branchTarget,
  output logic [XLEN-1:0]       pc,
  output logic [XLEN-1:0]       nextPc,
  output logic [XLEN-1:0]       nextNextPc,
  output logic                  redirectValid,
  output logic                  exlNow,
  output logic                  bevNow,
  output logic                  ivNow
);

  localparam logic [XLEN-1:0] STEP       = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] OFF_GEN    = XLEN'(32'h180);
  localparam logic [XLEN-1:0] OFF_IRQ    = XLEN'(32'h200);
  localparam logic [XLEN-1:0] STATUS_RST = XLEN'(1) << STATUS_CU1;

  logic [XLEN-1:0] regQ [NUM_REGS];
  logic [XLEN-1:0] regD [NUM_REGS];
  logic [XLEN-1:0] handler;
  logic            inSlot;
  logic [XLEN-1:0] statusQ, causeQ, shadowQ;

  assign statusQ = regQ[REG_STATUS];
  assign causeQ  = regQ[REG_CAUSE];
  assign shadowQ = regQ[REG_SHADOW];
  assign exlNow  = statusQ[STATUS_EXL];
  assign bevNow  = statusQ[STATUS_BEV];
  assign ivNow   = causeQ[CAUSE_IV];
  assign regRdData = regQ[regAddr];

  assign inSlot = (pc + STEP) != nextPc;

  always_comb begin
    case (strobe.vecSel)
      VEC_BASE:    handler = regQ[REG_EBASE];
      VEC_IRQ:     handler = regQ[REG_EBASE] + OFF_IRQ;
      VEC_FIXED:   handler = FIXED_VEC;
      default:     handler = regQ[REG_EBASE] + OFF_GEN;
    endcase
  end

  // Software write first, entry fields laid over it
  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) regD[i] = regQ[i];
    if (regWrEn) regD[regAddr] = regWrData;
    if (strobe.enter) begin
      regD[REG_STATUS][STATUS_EXL] = 1'b1;
      if (!exlNow && !bevNow) begin
        regD[REG_SHADOW][SHD_PREV_LO +: SET_W] = shadowQ[SHD_CUR_LO +: SET_W];
        regD[REG_SHADOW][SHD_CUR_LO +: SET_W]  = shadowQ[SHD_EXC_LO +: SET_W];
      end
      regD[REG_EPC] = inSlot ? (pc - STEP) : pc;
      regD[REG_CAUSE][CAUSE_BD] = inSlot;
      regD[REG_CAUSE][CAUSE_CODE_LO +: CODE_W] = strobe.code;
      regD[REG_CAUSE][CAUSE_CE_LO +: CE_W] = strobe.loadCe ? copNum : '0;
      if (strobe.wrBadAddr) regD[REG_BADVA] = badAddr;
      if (strobe.wrTlbCtx) begin
        regD[REG_EHI][EHI_VPN_LO +: VPN_W] = reqVpn2;
        regD[REG_EHI][0 +: ASID_W]         = reqAsid;
        regD[REG_CTX][CTX_VPN_LO +: VPN_W] = reqVpn2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= '0;
      regQ[REG_STATUS] <= STATUS_RST;
      regQ[REG_EBASE]  <= EBASE_RST;
      pc            <= RESET_VEC;
      nextPc        <= RESET_VEC + STEP;
      nextNextPc    <= RESET_VEC + STEP + STEP;
      redirectValid <= 1'b0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) regQ[i] <= regD[i];
      redirectValid <= strobe.enter;
      if (strobe.enter) begin
        pc         <= handler;
        nextPc     <= handler + STEP;
        nextNextPc <= handler + STEP + STEP;
      end else if (stepEn) begin
        pc <= nextPc;
        if (branchEn) begin
          nextPc     <= branchTarget;
          nextNextPc <= branchTarget + STEP;
        end else begin
          nextPc     <= nextNextPc;
          nextNextPc <= nextNextPc + STEP;
        end
      end
    end
  end

  // R3
  exl_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enter |=> statusQ[STATUS_EXL]);

  // R4
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enter && (exlNow || bevNow) && !(regWrEn && regAddr == REG_ADDR_W'(REG_SHADOW)))
      |=> (shadowQ[SET_W+SHD_PREV_LO-1:0] == $past(shadowQ[SET_W+SHD_PREV_LO-1:0])));

  // R5
  slot_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.enter |=> (causeQ[CAUSE_BD] == ($past(pc) + STEP != $past(nextPc))));

  // R6
  ce_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.enter && !strobe.loadCe) |=> (causeQ[CAUSE_CE_LO +: CE_W] == '0));

  // R11
  chain_chk: assert property (@(posedge clk) disable iff (!rstN)
    redirectValid |-> (nextPc == pc + STEP && nextNextPc == pc + STEP + STEP));

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] RESET_VEC  = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] EBASE_RST  = 32'h8000_0000,
  parameter logic [XLEN-1:0] FIXED_VEC  = 32'hBFC0_0200,
  parameter int              INSN_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  excValid,
  input  logic [3:0]            excKind,
  input  logic [XLEN-1:0]       badAddr,
  input  logic [VPN_W-1:0]      reqVpn2,
  input  logic [ASID_W-1:0]     reqAsid,
  input  logic [CE_W-1:0]       copNum,
  input  logic                  regWrEn,
  input  logic [REG_ADDR_W-1:0] regAddr,
  input  logic [XLEN-1:0]       regWrData,
  output logic [XLEN-1:0]       regRdData,
  input  logic                  stepEn,
  input  logic                  branchEn,
  input  logic [XLEN-1:0]       branchTarget,
  output logic [XLEN-1:0]       pc,
  output logic [XLEN-1:0]       nextPc,
  output logic [XLEN-1:0]       nextNextPc,
  output logic                  redirectValid
);

  entry_strobe_t strobe;
  logic exlNow, bevNow, ivNow;

  exc_entry_decode u_decode (
    .excValid (excValid),
    .excKind  (excKind),
    .exlNow   (exlNow),
    .bevNow   (bevNow),
    .ivNow    (ivNow),
    .strobe   (strobe)
  );

  exc_entry_regs #(
    .XLEN       (XLEN),
    .RESET_VEC  (RESET_VEC),
    .EBASE_RST  (EBASE_RST),
    .FIXED_VEC  (FIXED_VEC),
    .INSN_BYTES (INSN_BYTES)
  ) u_regs (
    .clk           (clk),
    .rstN          (rstN),
    .strobe        (strobe),
    .badAddr       (badAddr),
    .reqVpn2       (reqVpn2),
    .reqAsid       (reqAsid),
    .copNum        (copNum),
    .regWrEn       (regWrEn),
    .regAddr       (regAddr),
    .regWrData     (regWrData),
    .regRdData     (regRdData),
    .stepEn        (stepEn),
    .branchEn      (branchEn),
    .branchTarget  (branchTarget),
    .pc            (pc),
    .nextPc        (nextPc),
    .nextNextPc    (nextNextPc),
    .redirectValid (redirectValid),
    .exlNow        (exlNow),
    .bevNow        (bevNow),
    .ivNow         (ivNow)
  );

endmodule

// File: tb/exc_entry_unit_bench.sv
module exc_entry_unit_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        excValid = 1'b0;
  logic [3:0]  excKind = '0;
  logic [31:0] badAddr = '0;
  logic [18:0] reqVpn2 = '0;
  logic [7:0]  reqAsid = '0;
  logic [1:0]  copNum = '0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        stepEn = 1'b0;
  logic        branchEn = 1'b0;
  logic [31:0] branchTarget = '0;
  logic [31:0] pc, nextPc, nextNextPc;
  logic        redirectValid;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exc_entry_unit u_exc_entry_unit (
    .clk(clk), .rstN(rstN), .excValid(excValid), .excKind(excKind),
    .badAddr(badAddr), .reqVpn2(reqVpn2), .reqAsid(reqAsid), .copNum(copNum),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .stepEn(stepEn), .branchEn(branchEn),
    .branchTarget(branchTarget), .pc(pc), .nextPc(nextPc),
    .nextNextPc(nextNextPc), .redirectValid(redirectValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readReg(input logic [2:0] a, output logic [31:0] v);
    regAddr = a;
    #1;
    v = regRdData;
  endtask

  task automatic checkReg(input string tag, input logic [2:0] a, input logic [31:0] exp);
    logic [31:0] v;
    readReg(a, v);
    check(tag, v, exp);
  endtask

  task automatic writeReg(input logic [2:0] a, input logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic raise(input logic [3:0] kind, input logic [31:0] addr,
                       input logic [18:0] vpn, input logic [7:0] asid,
                       input logic [1:0] cop, input logic wr,
                       input logic [2:0] wa, input logic [31:0] wd);
    excValid = 1'b1; excKind = kind; badAddr = addr;
    reqVpn2 = vpn; reqAsid = asid; copNum = cop;
    regWrEn = wr; regAddr = wa; regWrData = wd;
    tick();
    excValid = 1'b0; regWrEn = 1'b0;
  endtask

  task automatic testReset();
    check("R1 pc", pc, 32'hBFC0_0000);
    check("R1 nextPc", nextPc, 32'hBFC0_0004);
    check("R1 nextNextPc", nextNextPc, 32'hBFC0_0008);
    check("R1 redirect", {31'b0, redirectValid}, 32'h0);
    checkReg("R1 status", 3'd0, 32'h2000_0000);
    checkReg("R1 cause", 3'd1, 32'h0);
    checkReg("R1 epc", 3'd2, 32'h0);
    checkReg("R1 ebase", 3'd7, 32'h8000_0000);
  endtask

  task automatic testSyscall();
    stepEn = 1'b1; tick(); tick(); stepEn = 1'b0;
    check("R5 step pc", pc, 32'hBFC0_0008);
    writeReg(3'd6, 32'h0000_5002);
    raise(4'd8, 0, 0, 0, 0, 1'b0, 0, 0);
    check("R7 syscall pc", pc, 32'h8000_0180);
    check("R11 nextPc", nextPc, 32'h8000_0184);
    check("R11 nextNextPc", nextNextPc, 32'h8000_0188);
    check("R11 pulse high", {31'b0, redirectValid}, 32'h1);
    checkReg("R5 epc plain", 3'd2, 32'hBFC0_0008);
    checkReg("R2 cause syscall", 3'd1, 32'h0000_0020);
    checkReg("R3 status exl", 3'd0, 32'h2000_0002);
    checkReg("R4 shadow swap", 3'd6, 32'h0000_5085);
    tick();
    check("R11 pulse low", {31'b0, redirectValid}, 32'h0);
    check("R11 pc held", pc, 32'h8000_0180);
  endtask

  task automatic testRefill();
    raise(4'd2, 32'h0040_2468, 19'h12345, 8'h3C, 0, 1'b0, 0, 0);
    check("R8 refill exl set", pc, 32'h8000_0180);
    checkReg("R2 cause tlb load", 3'd1, 32'h0000_0008);
    checkReg("R3 status exl again", 3'd0, 32'h2000_0002);
    checkReg("R4 shadow gated exl", 3'd6, 32'h0000_5085);
    checkReg("R12 badva", 3'd3, 32'h0040_2468);
    checkReg("R12 entryhi", 3'd4, 32'h2468_A03C);
    checkReg("R12 context", 3'd5, 32'h0012_3450);
    writeReg(3'd0, 32'h2000_0000);
    raise(4'd4, 32'h0000_1000, 19'h00001, 8'h01, 0, 1'b0, 0, 0);
    check("R8 refill exl clear", pc, 32'h8000_0000);
    checkReg("R2 cause tlb store", 3'd1, 32'h0000_000C);
    checkReg("R4 shadow swap 2", 3'd6, 32'h0000_5145);
    checkReg("R12 entryhi 2", 3'd4, 32'h0000_2001);
  endtask

  task automatic testSlot();
    writeReg(3'd0, 32'h2000_0000);
    stepEn = 1'b1; branchEn = 1'b1; branchTarget = 32'h8000_1000;
    tick();
    stepEn = 1'b0; branchEn = 1'b0;
    check("R5 branch nextPc", nextPc, 32'h8000_1000);
    raise(4'd9, 0, 0, 0, 0, 1'b0, 0, 0);
    checkReg("R5 epc slot", 3'd2, 32'h8000_0000);
    checkReg("R5 cause bd", 3'd1, 32'h8000_0024);
    check("R7 break pc", pc, 32'h8000_0180);
  endtask

  task automatic testIrq();
    writeReg(3'd0, 32'h2000_0000);
    writeReg(3'd1, 32'h0080_0000);
    raise(4'd0, 0, 0, 0, 0, 1'b0, 0, 0);
    check("R9 irq iv set", pc, 32'h8000_0200);
    checkReg("R9 cause irq", 3'd1, 32'h0080_0000);
    writeReg(3'd0, 32'h2000_0000);
    writeReg(3'd1, 32'h0);
    raise(4'd0, 0, 0, 0, 0, 1'b0, 0, 0);
    check("R9 irq iv clear", pc, 32'h8000_0180);
  endtask

  task automatic testOvfCop();
    logic [31:0] shd;
    writeReg(3'd0, 32'h2040_0000);
    readReg(3'd6, shd);
    raise(4'd12, 0, 0, 0, 0, 1'b0, 0, 0);
    check("R10 ovf bev", pc, 32'hBFC0_0200);
    checkReg("R3 status bev", 3'd0, 32'h2040_0002);
    checkReg("R4 shadow gated bev", 3'd6, shd);
    checkReg("R2 cause ovf", 3'd1, 32'h0000_0030);
    writeReg(3'd0, 32'h2000_0000);
    raise(4'd11, 0, 0, 0, 2'd2, 1'b0, 0, 0);
    checkReg("R6 ce loaded", 3'd1, 32'h2000_002C);
    check("R7 cop pc", pc, 32'h8000_0180);
    writeReg(3'd0, 32'h2000_0000);
    raise(4'd12, 0, 0, 0, 2'd3, 1'b0, 0, 0);
    check("R10 ovf no bev", pc, 32'h8000_0180);
    checkReg("R6 ce cleared", 3'd1, 32'h0000_0030);
  endtask

  task automatic testAddr();
    writeReg(3'd7, 32'h9000_0000);
    raise(4'd7, 32'h0000_BEEF, 19'h7FFFF, 8'hFF, 0, 1'b0, 0, 0);
    check("R7 ebase moved", pc, 32'h9000_0180);
    checkReg("R12 badva addr", 3'd3, 32'h0000_BEEF);
    checkReg("R12 entryhi kept", 3'd4, 32'h0000_2001);
    checkReg("R12 context kept", 3'd5, 32'h0000_0010);
    checkReg("R2 cause addr st", 3'd1, 32'h0000_0014);
    raise(4'd8, 32'h0000_0055, 0, 0, 0, 1'b0, 0, 0);
    checkReg("R12 badva kept", 3'd3, 32'h0000_BEEF);
  endtask

  task automatic testCollide();
    raise(4'd8, 0, 0, 0, 0, 1'b1, 3'd2, 32'h1234_5678);
    checkReg("R13 epc write dropped", 3'd2, 32'h9000_0180);
    raise(4'd8, 0, 0, 0, 0, 1'b1, 3'd0, 32'h0000_0000);
    checkReg("R13 status merge", 3'd0, 32'h0000_0002);
    raise(4'd8, 0, 0, 0, 0, 1'b1, 3'd7, 32'hA000_0000);
    check("R13 old ebase vector", pc, 32'h9000_0180);
    checkReg("R13 ebase written", 3'd7, 32'hA000_0000);
  endtask

  task automatic testUnknownPort();
    logic [31:0] cz, pz;
    readReg(3'd1, cz);
    pz = pc;
    raise(4'd15, 0, 0, 0, 0, 1'b0, 0, 0);
    check("R2 kind15 no pulse", {31'b0, redirectValid}, 32'h0);
    check("R2 kind15 pc", pc, pz);
    checkReg("R2 kind15 cause", 3'd1, cz);
    writeReg(3'd5, 32'hCAFE_F00D);
    checkReg("R14 context rw", 3'd5, 32'hCAFE_F00D);
    writeReg(3'd3, 32'h0BAD_0BAD);
    checkReg("R14 badva rw", 3'd3, 32'h0BAD_0BAD);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSyscall();
    testRefill();
    testSlot();
    testIrq();
    testOvfCop();
    testAddr();
    testCollide();
    testUnknownPort();
    finishRun();
  end

endmodule